// File: doc/BRIEF.md
# Processor-Side Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers a set of pending interrupt candidates, each with an 8-bit priority and, for the software-raised ones, a 3-bit requesting-processor number. The block picks the most urgent candidate that is not already being serviced. It decides whether that candidate may interrupt the processor under the priority mask and the preemption rules, and drives the IRQ line.

The processor talks to the block through a single-cycle register port. Reads return data in the same cycle, and any side effect takes place at the clock edge that ends the access. Reading the acknge register claims the selected interrupt and marks it active. Writing an ID to the end-of-service register retires it. Both events are reported to the distributor on one-cycle pulses, so that it can clear pending state. The block keeps its own active set and derives the running priority from it. Preemption compares only the group part of the priority, which a programmable binary point splits off.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, irq_o is 0, the control register (0x00) reads 0, the priority mask (0x04) reads 0, the binary point (0x08) reads 0, the running priority (0x14) reads 0xFF, and an acknowledge read returns 1023.
- R2: Control bit 0 (offset 0x00) is the enable, the priority mask at 0x04 holds 8 bits, and the binary point at 0x08 keeps only write-data bits [2:0]. The identification register at 0xFC returns the IDENT parameter, and writes to read-only offsets (0x14, 0x18, 0xFC) have no effect.
- R3: The highest-pending register (0x18) returns in bits [9:0] the ID of the pending, not-active candidate with the numerically lowest priority. Ties go to the lowest ID. It returns 1023 when there is none, and reading it changes no state and raises no acknowledge pulse.
- R4: A candidate qualifies for signalling only if its priority is numerically strictly below the priority mask.
- R5: An acknowledge read (0x0C) with a qualifying candidate and the enable set returns {19'b0, source[2:0], id[9:0]}. The source is the candidate's source input for IDs below N_SW and 0 otherwise. The interrupt becomes active, and ack_pulse with ack_id is high for the one cycle after the read.
- R6: An acknowledge read with no qualifying candidate, or with the enable clear, returns 1023, changes no state and gives no ack_pulse.
- R7: Writing an ID to 0x10 that is active makes it inactive, and eoi_pulse with eoi_id is high for the one cycle after the write. A write naming an ID that is not active is ignored.
- R8: The running priority register (0x14) reads the lowest priority value among active interrupts (the priority captured when each was acknowledged), or 0xFF when none is active.
- R9: While any interrupt is active, a candidate qualifies only if (prio & G) < (running & G), where G = 8'hFF << (binary_point + 1) truncated to 8 bits. With the binary point at 7, nothing preempts.
- R10: irq_o equals, one cycle later, the enable bit ANDed with the existence of a qualifying candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_pend | input | N_IRQ | Pending flag per interrupt ID from the distributor |
| cand_prio | input | N_IRQ*8 | Priority per ID, ID i in bits [8i+7:8i] |
| cand_src | input | N_IRQ*3 | Requesting processor per ID, ID i in bits [3i+2:3i] |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_pulse | output | 1 | One-cycle acknowledge event to the distributor |
| ack_id | output | 10 | ID acknowledged |
| eoi_pulse | output | 1 | One-cycle end-of-service event to the distributor |
| eoi_id | output | 10 | ID retired |

## Verification
A corrupted active set shows up at the running priority register in the access right after the acknowledge or end-of-service. It also shows up at the highest-pending register, which would either repeat an ID being serviced or skip a free one. A wrong group mask or preemption compare is visible one cycle later, on irq_o, when a nearly equal candidate arrives during service. A selection error shows at once in the highest-pending read data, which the tie and empty cases target directly.

// File: rtl/cpuif_pkg.sv
// Shared widths, register offsets and special values for the CPU interrupt interface.
package cpuif_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 3;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ID_W-1:0]   NO_IRQ_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

    localparam logic [ADDR_W-1:0] OFF_CTL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PMSK = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_BPT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_ACK  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_EOS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_RUN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_HPND = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IDNT = 8'hFC;
endpackage

// File: rtl/cpuif_select.sv
// Picks the most urgent eligible candidate.
// Assumes: priorities are packed 8 bits per ID, and lower value means more urgent.
// Ties resolve to the lowest ID. Purely combinational.
module cpuif_select
    import cpuif_pkg::*;
#(
    parameter int N_IRQ = 32,
    parameter int N_SW  = 16
) (
    input  logic [N_IRQ-1:0]        elig,
    input  logic [N_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [N_IRQ*SRC_W-1:0]  src_flat,
    output logic                    sel_valid,
    output logic [ID_W-1:0]         sel_id,
    output logic [PRIO_W-1:0]       sel_prio,
    output logic [SRC_W-1:0]        sel_src
);
    // Linear scan; strict compare keeps the earlier (lower) ID on ties.
    always_comb begin
        sel_valid = 1'b0;
        sel_id    = NO_IRQ_ID;
        sel_prio  = IDLE_PRIO;
        sel_src   = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (elig[i] && (!sel_valid || prio_flat[i*PRIO_W +: PRIO_W] < sel_prio)) begin
                sel_valid = 1'b1;
                sel_id    = ID_W'(i);
                sel_prio  = prio_flat[i*PRIO_W +: PRIO_W];
                sel_src   = (i < N_SW) ? src_flat[i*SRC_W +: SRC_W] : '0;
            end
        end
    end

    // A chosen ID must be one offered as eligible.
    always_comb begin
        if (sel_valid) begin
            AST_SEL_IS_ELIGIBLE: assert (elig[sel_id[$clog2(N_IRQ)-1:0]]); // R3
        end
    end
endmodule

// File: rtl/cpuif_active.sv
// Holds the set of acknowledged, not yet retired interrupts with their captured priority.
// Assumes: set and clear never name the same ID in one cycle (acknowledge excludes
// active IDs, and retire requires active). Derives the running priority.
module cpuif_active
    import cpuif_pkg::*;
#(
    parameter int N_IRQ = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ID_W-1:0]   set_id,
    input  logic [PRIO_W-1:0] set_prio,
    input  logic              clr_req,
    input  logic [ID_W-1:0]   clr_id,
    output logic              clr_ok,
    output logic [N_IRQ-1:0]  act_o,
    output logic [PRIO_W-1:0] run_prio
);
    localparam int NIW = $clog2(N_IRQ);

    logic [N_IRQ-1:0]  act_q;
    logic [PRIO_W-1:0] cap_q [N_IRQ];

    // A retire request is honoured only for an in-range, active ID.
    always_comb clr_ok = clr_req && (clr_id < ID_W'(N_IRQ)) && act_q[clr_id[NIW-1:0]];

    // Active flags and captured priorities update on acknowledge and retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            for (int i = 0; i < N_IRQ; i++) cap_q[i] <= IDLE_PRIO;
        end else begin
            if (set_en) begin
                act_q[set_id[NIW-1:0]] <= 1'b1;
                cap_q[set_id[NIW-1:0]] <= set_prio;
            end
            if (clr_ok) act_q[clr_id[NIW-1:0]] <= 1'b0;
        end
    end

    // Running priority is the most urgent captured priority among active IDs.
    always_comb begin
        run_prio = IDLE_PRIO;
        for (int i = 0; i < N_IRQ; i++)
            if (act_q[i] && cap_q[i] < run_prio) run_prio = cap_q[i];
    end

    assign act_o = act_q;

    AST_NO_REACK: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !act_q[set_id[NIW-1:0]]); // R3
    AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok |=> !act_q[$past(clr_id[NIW-1:0])]); // R7
endmodule

// File: rtl/cpu_irq_iface.sv
// Processor-side interrupt interface: register port, qualification, IRQ line and
// acknowledge/retire events to the distributor.
// Assumes: the distributor clears pending after ack_pulse, and bus accesses are single-cycle.
module cpu_irq_iface
    import cpuif_pkg::*;
#(
    parameter int          N_IRQ = 32,
    parameter int          N_SW  = 16,
    parameter logic [31:0] IDENT = 32'h0012_0043
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IRQ-1:0]        cand_pend,
    input  logic [N_IRQ*PRIO_W-1:0] cand_prio,
    input  logic [N_IRQ*SRC_W-1:0]  cand_src,
    input  logic                    bus_en,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    irq_o,
    output logic                    ack_pulse,
    output logic [ID_W-1:0]         ack_id,
    output logic                    eoi_pulse,
    output logic [ID_W-1:0]         eoi_id
);
    logic              ctl_en_q;
    logic [PRIO_W-1:0] pmask_q;
    logic [2:0]        bpt_q;
    logic              irq_q;

    logic [N_IRQ-1:0]  act;
    logic [PRIO_W-1:0] run_prio;
    logic              sel_valid;
    logic [ID_W-1:0]   sel_id;
    logic [PRIO_W-1:0] sel_prio;
    logic [SRC_W-1:0]  sel_src;
    logic [PRIO_W-1:0] grp_mask;
    logic              qualify, rd_hit, wr_hit, ack_take, clr_ok;

    cpuif_select #(.N_IRQ(N_IRQ), .N_SW(N_SW)) i_sel (
        .elig(cand_pend & ~act), .prio_flat(cand_prio), .src_flat(cand_src),
        .sel_valid(sel_valid), .sel_id(sel_id), .sel_prio(sel_prio), .sel_src(sel_src)
    );

    // Bus decode and the qualification rules (mask, then group preemption).
    always_comb begin
        rd_hit   = bus_en && !bus_wr;
        wr_hit   = bus_en && bus_wr;
        grp_mask = PRIO_W'(9'h1FF << (4'(bpt_q) + 4'd1));
        qualify  = sel_valid && (sel_prio < pmask_q) &&
                   ((act == '0) || ((sel_prio & grp_mask) < (run_prio & grp_mask)));
        ack_take = rd_hit && (bus_addr == OFF_ACK) && ctl_en_q && qualify;
    end

    cpuif_active #(.N_IRQ(N_IRQ)) i_act (
        .clk(clk), .rst_n(rst_n),
        .set_en(ack_take), .set_id(sel_id), .set_prio(sel_prio),
        .clr_req(wr_hit && (bus_addr == OFF_EOS)), .clr_id(bus_wdata[ID_W-1:0]),
        .clr_ok(clr_ok), .act_o(act), .run_prio(run_prio)
    );

    // Read data mux, returned in the access cycle.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTL:  bus_rdata = {31'b0, ctl_en_q};
            OFF_PMSK: bus_rdata = {24'b0, pmask_q};
            OFF_BPT:  bus_rdata = {29'b0, bpt_q};
            OFF_ACK:  bus_rdata = (ctl_en_q && qualify) ? {19'b0, sel_src, sel_id}
                                                        : {22'b0, NO_IRQ_ID};
            OFF_RUN:  bus_rdata = {24'b0, run_prio};
            OFF_HPND: bus_rdata = {22'b0, sel_valid ? sel_id : NO_IRQ_ID};
            OFF_IDNT: bus_rdata = IDENT;
            default:  bus_rdata = '0;
        endcase
    end

    // Writable registers, registered IRQ line and distributor event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en_q  <= 1'b0;
            pmask_q   <= '0;
            bpt_q     <= '0;
            irq_q     <= 1'b0;
            ack_pulse <= 1'b0;
            ack_id    <= '0;
            eoi_pulse <= 1'b0;
            eoi_id    <= '0;
        end else begin
            irq_q     <= ctl_en_q && qualify;
            ack_pulse <= ack_take;
            eoi_pulse <= clr_ok;
            if (ack_take) ack_id <= sel_id;
            if (clr_ok)   eoi_id <= bus_wdata[ID_W-1:0];
            if (wr_hit) begin
                case (bus_addr)
                    OFF_CTL:  ctl_en_q <= bus_wdata[0];
                    OFF_PMSK: pmask_q  <= bus_wdata[PRIO_W-1:0];
                    OFF_BPT:  bpt_q    <= bus_wdata[2:0];
                    default:  ;
                endcase
            end
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctl_en_q)); // R10
    AST_ACK_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> $past(sel_prio < pmask_q)); // R4
    AST_ACK_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> $past(rd_hit && bus_addr == OFF_ACK && ctl_en_q)); // R5
    AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> $past(wr_hit && bus_addr == OFF_EOS)); // R7
    AST_ACK_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> (ack_id < ID_W'(N_IRQ))); // R5
endmodule

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;
    localparam int N = 32;
    localparam logic [31:0] IDV = 32'h0012_0043;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pend = '0;
    logic [7:0]  prio_arr [N];
    logic [2:0]  src_arr  [N];
    logic [N*8-1:0] cand_prio;
    logic [N*3-1:0] cand_src;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq_o, ack_pulse, eoi_pulse;
    logic [9:0]  ack_id, eoi_id;
    int n_chk = 0, n_bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) begin
        cand_prio[i*8 +: 8] = prio_arr[i];
        cand_src[i*3 +: 3]  = src_arr[i];
    end

    cpu_irq_iface #(.N_IRQ(N), .N_SW(16), .IDENT(IDV)) i_cpu_irq_iface (
        .clk(clk), .rst_n(rst_n), .cand_pend(pend), .cand_prio(cand_prio), .cand_src(cand_src),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .ack_pulse(ack_pulse), .ack_id(ack_id),
        .eoi_pulse(eoi_pulse), .eoi_id(eoi_id));

    typedef struct packed {
        logic [31:0] pend; logic [4:0] ia; logic [7:0] pa; logic [4:0] ib; logic [7:0] pb; logic [9:0] exp;
    } vec_t;
    localparam vec_t VEC [6] = '{
        '{32'h0000_0001, 5'd0,  8'hA0, 5'd0,  8'hA0, 10'd0},
        '{32'h8000_0010, 5'd31, 8'h10, 5'd4,  8'hA0, 10'd31},
        '{32'h0000_0300, 5'd8,  8'h50, 5'd9,  8'h50, 10'd8},
        '{32'h00F0_0000, 5'd23, 8'h20, 5'd21, 8'h30, 10'd23},
        '{32'h0000_0000, 5'd0,  8'hA0, 5'd0,  8'hA0, 10'd1023},
        '{32'h0001_0004, 5'd16, 8'h00, 5'd2,  8'h00, 10'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_en = 0;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin prio_arr[i] = 8'hA0; src_arr[i] = 3'd0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 0);
        rd(8'h00, rv); chk("R1 ctl", rv, 0);
        rd(8'h04, rv); chk("R1 pmask", rv, 0);
        rd(8'h08, rv); chk("R1 bpt", rv, 0);
        rd(8'h14, rv); chk("R1 running", rv, 32'hFF);
        rd(8'h0C, rv); chk("R1 ack", rv, 1023);
        // R2 register widths and read-only offsets
        rd(8'hFC, rv); chk("R2 ident", rv, IDV);
        wr(8'h08, 32'hFF); rd(8'h08, rv); chk("R2 bpt width", rv, 7);
        wr(8'h08, 32'h0);
        wr(8'h14, 32'h0); rd(8'h14, rv); chk("R2 running ro", rv, 32'hFF);
        wr(8'hFC, 32'h0); rd(8'hFC, rv); chk("R2 ident ro", rv, IDV);
        wr(8'h00, 32'h1); wr(8'h04, 32'hF0);
        rd(8'h00, rv); chk("R2 ctl", rv, 1);
        rd(8'h04, rv); chk("R2 pmask", rv, 32'hF0);
        // R3 and R10 selection table
        for (int v = 0; v < 6; v++) begin
            for (int i = 0; i < N; i++) prio_arr[i] = 8'hA0;
            pend = VEC[v].pend;
            prio_arr[VEC[v].ia] = VEC[v].pa;
            prio_arr[VEC[v].ib] = VEC[v].pb;
            rd(8'h18, rv); chk("R3 hppir", rv, {22'b0, VEC[v].exp});
            chk("R3 no ack side effect", {31'b0, ack_pulse}, 0);
            settle();
            chk("R10 irq vs table", {31'b0, irq_o}, {31'b0, VEC[v].exp != 10'd1023});
        end
        // R4 strict mask
        for (int i = 0; i < N; i++) prio_arr[i] = 8'hA0;
        pend = 32'h0000_0020; prio_arr[5] = 8'h80;
        wr(8'h04, 32'h80); settle();
        chk("R4 equal to mask blocked", {31'b0, irq_o}, 0);
        rd(8'h0C, rv); chk("R6 ack spurious", rv, 1023);
        chk("R6 no pulse", {31'b0, ack_pulse}, 0);
        wr(8'h04, 32'h81); settle();
        chk("R4 below mask passes", {31'b0, irq_o}, 1);
        // R5 acknowledge with software source
        pend[3] = 1; prio_arr[3] = 8'h40; src_arr[3] = 3'd5;
        rd(8'h0C, rv); chk("R5 ack data", rv, 32'h0000_1403);
        chk("R5 pulse", {31'b0, ack_pulse}, 1);
        chk("R5 ack id", {22'b0, ack_id}, 3);
        pend[3] = 0;
        rd(8'h14, rv); chk("R8 running", rv, 32'h40);
        rd(8'h18, rv); chk("R3 hppir after ack", rv, 5);
        settle(); chk("R9 no preempt equal group", {31'b0, irq_o}, 0);
        rd(8'h0C, rv); chk("R6 ack during service", rv, 1023);
        // R9 binary point gating
        pend[20] = 1; prio_arr[20] = 8'h3F; src_arr[20] = 3'd7;
        wr(8'h08, 32'h6); settle();
        chk("R9 coarse group blocks", {31'b0, irq_o}, 0);
        wr(8'h08, 32'h0); settle();
        chk("R9 fine group preempts", {31'b0, irq_o}, 1);
        rd(8'h0C, rv); chk("R5 non-software src zero", rv, 32'h14);
        pend[20] = 0;
        rd(8'h14, rv); chk("R8 nested running", rv, 32'h3F);
        // R7 retire
        wr(8'h10, 32'd20);
        chk("R7 eoi pulse", {31'b0, eoi_pulse}, 1);
        chk("R7 eoi id", {22'b0, eoi_id}, 20);
        rd(8'h14, rv); chk("R8 back to outer", rv, 32'h40);
        wr(8'h10, 32'd20);
        chk("R7 inactive ignored", {31'b0, eoi_pulse}, 0);
        rd(8'h14, rv); chk("R7 running unchanged", rv, 32'h40);
        wr(8'h10, 32'd3);
        rd(8'h14, rv); chk("R8 idle", rv, 32'hFF);
        settle(); chk("R10 irq after idle", {31'b0, irq_o}, 1);
        // R10 and R6 disabled interface
        wr(8'h00, 32'h0); settle();
        chk("R10 disabled irq", {31'b0, irq_o}, 0);
        rd(8'h0C, rv); chk("R6 disabled ack", rv, 1023);
        chk("R6 disabled no pulse", {31'b0, ack_pulse}, 0);
        rd(8'h18, rv); chk("R3 hppir while disabled", rv, 5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule